// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a synthesizable model of a synchronous SRAM with a registered read path and a 2-bit burst counter. The memory depth is set by a parameter. Each word holds 18 bits, arranged as two 9-bit byte lanes. All control inputs, the address and the write data are sampled on the rising clock edge. The common data bus is modelled as three signals: a data input, a data output and an output-enable.

An access opens at an edge where an address strobe is low and every chip enable is active. The block has two strobes, a processor strobe and a controller strobe, and they differ in precedence and in write latency. After the opening edge, an advance input steps the burst counter through four positions. The counter follows a linear or an interleaved order, chosen by a static order input. A sleep input blocks all accesses after a two-cycle entry delay, and a further two-cycle recovery is needed after it is released. Memory contents are kept through sleep.

Top module: `burst_sram`

## Requirements
- R1: An access opens at an edge where a recognised strobe is low and sel1_n=0, sel2=1, sel3_n=0. A recognised strobe with any chip enable inactive deselects the block.
- R2: When both strobes are low, the processor strobe takes precedence. While sel1_n is high, the processor strobe is ignored, and an open burst continues as if no strobe were present.
- R3: A processor-strobe access never writes on its opening edge. The write controls sampled at the next edge decide whether that address is written.
- R4: A controller-strobe access writes on its opening edge, using the write controls sampled at that edge. Advance is ignored on that edge.
- R5: wr_all_n=0 writes both lanes whatever lane_sel_n holds. Otherwise, wr_byte_n=0 writes only the lanes whose lane_sel_n bit is 0, where bit 0 maps to data[8:0] and bit 1 maps to data[17:9]. Unselected lanes keep their contents.
- R6: Read data for an address captured at edge k is driven on dq_out after edge k+1.
- R7: dq_oe is 0 whenever oe_n is high. It is also 0 in the cycle after an access opens from the deselected state, and right after an edge that deselects.
- R8: dq_oe is 0 while wr_all_n or wr_byte_n is low, whatever oe_n holds.
- R9: At the opening edge, addr[1:0] loads the burst start. Each later edge with advance_n=0 moves to the next burst position, wrapping after four, for both reads and writes.
- R10: With order_ilv=0 the low address bits are start+index mod 4. With order_ilv=1 they are start XOR index.
- R11: From the second edge after sleep_req rises, until the second edge after it falls, all strobes are ignored, no write occurs and dq_oe is 0. Stored data is preserved.
- R12: After reset the block is deselected, with dq_oe=0 and the burst index at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| addr | input | AW | Word address |
| sel1_n | input | 1 | Chip enable 1, active low; also gates the processor strobe |
| sel2 | input | 1 | Chip enable 2, active high |
| sel3_n | input | 1 | Chip enable 3, active low |
| cpu_strobe_n | input | 1 | Processor address strobe, active low |
| ctl_strobe_n | input | 1 | Controller address strobe, active low |
| advance_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Write both lanes, active low |
| wr_byte_n | input | 1 | Lane-masked write enable, active low |
| lane_sel_n | input | 2 | Lane selects, active low |
| order_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| sleep_req | input | 1 | Sleep request |
| oe_n | input | 1 | Output enable, active low, combinational |
| dq_in | input | 18 | Write data |
| dq_out | output | 18 | Read data |
| dq_oe | output | 1 | Bus drive enable |

## Verification
The bench runs four-beat bursts from every start position in both orders, so a wrong wrap or a confused order shows up as a mismatched word. It drives both strobes low together with a write pending. If the controller strobe were allowed to win, that address would be corrupted and the read-back would fail. Lane masks are exercised with each lane alone, with no lane, and with a global write, which would expose a swapped lane or a global write that honours the lane selects. Further checks cover the output masking after deselect, the forced tri-state on write controls, and strobes that are ignored while sel1_n is high or during sleep recovery. A design that gets any of these wrong drives the bus too early, ends a burst, or overwrites data that must survive.

// File: rtl/burst_sram.sv
module burst_sram #(
  parameter int AW = 8,
  parameter int LW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          sel1_n,
  input  logic          sel2,
  input  logic          sel3_n,
  input  logic          cpu_strobe_n,
  input  logic          ctl_strobe_n,
  input  logic          advance_n,
  input  logic          wr_all_n,
  input  logic          wr_byte_n,
  input  logic [1:0]    lane_sel_n,
  input  logic          order_ilv,
  input  logic          sleep_req,
  input  logic          oe_n,
  input  logic [2*LW-1:0] dq_in,
  output logic [2*LW-1:0] dq_out,
  output logic          dq_oe
);
  localparam int DW = 2 * LW;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] data_q;
  logic          active, rd_pend, out_valid, zz1, zz2;
  logic [AW-3:0] hi;
  logic [1:0]    start_lo, idx;

  function automatic logic [1:0] burst_lo(input logic [1:0] s, input logic [1:0] i, input logic ilv);
    return ilv ? (s ^ i) : (s + i);
  endfunction

  wire blocked   = zz1 | zz2;
  wire all_en    = !sel1_n && sel2 && !sel3_n;
  wire cpu_seen  = !cpu_strobe_n && !sel1_n;
  wire ctl_seen  = !ctl_strobe_n && !cpu_seen;
  wire strobe    = !blocked && (cpu_seen || ctl_seen);
  wire start_evt = strobe && all_en;
  wire desel_evt = strobe && !all_en;
  wire cont      = !blocked && active && !strobe;
  wire wr_cyc    = !wr_all_n || !wr_byte_n;
  wire [1:0] lanes = !wr_all_n ? 2'b11 : (!wr_byte_n ? ~lane_sel_n : 2'b00);
  wire [1:0] idx_n = advance_n ? idx : idx + 2'd1;
  wire [AW-1:0] cur_addr  = {hi, burst_lo(start_lo, idx, order_ilv)};
  wire [AW-1:0] cont_addr = {hi, burst_lo(start_lo, idx_n, order_ilv)};
  wire do_wr = (start_evt && ctl_seen && wr_cyc) || (cont && wr_cyc);
  wire [AW-1:0] wr_addr = start_evt ? addr : cont_addr;
  wire [1:0] we = do_wr ? lanes : 2'b00;

  always_ff @(posedge clk) begin
    for (int l = 0; l < 2; l++)
      if (we[l]) mem[wr_addr][l*LW +: LW] <= dq_in[l*LW +: LW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zz1 <= 1'b0;
      zz2 <= 1'b0;
      active <= 1'b0;
      rd_pend <= 1'b0;
      out_valid <= 1'b0;
      hi <= '0;
      start_lo <= 2'd0;
      idx <= 2'd0;
      data_q <= '0;
    end else begin
      zz1 <= sleep_req;
      zz2 <= zz1;
      data_q <= mem[cur_addr];
      out_valid <= rd_pend && !blocked && !desel_evt && !do_wr;
      if (blocked) begin
        active <= 1'b0;
        rd_pend <= 1'b0;
      end else if (start_evt) begin
        active <= 1'b1;
        hi <= addr[AW-1:2];
        start_lo <= addr[1:0];
        idx <= 2'd0;
        rd_pend <= !(ctl_seen && wr_cyc);
      end else if (desel_evt) begin
        active <= 1'b0;
        rd_pend <= 1'b0;
      end else if (active) begin
        idx <= idx_n;
        rd_pend <= !wr_cyc;
      end else begin
        rd_pend <= 1'b0;
      end
    end
  end

  assign dq_out = data_q;
  assign dq_oe  = out_valid && !oe_n && !blocked && !wr_cyc;
endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       oe_n,
  input logic       wr_all_n,
  input logic       wr_byte_n,
  input logic       cpu_strobe_n,
  input logic       sel1_n,
  input logic       advance_n,
  input logic       dq_oe,
  input logic       blocked,
  input logic       active,
  input logic       start_evt,
  input logic       desel_evt,
  input logic       cont,
  input logic [1:0] we,
  input logic [1:0] idx
);
  p_oe_off_r7: assert property (@(posedge clk) disable iff (!rst_n) oe_n |-> !dq_oe);
  p_first_mask_r7: assert property (@(posedge clk) disable iff (!rst_n) (start_evt && !active) |=> !dq_oe);
  p_deselect_r1: assert property (@(posedge clk) disable iff (!rst_n) desel_evt |=> !dq_oe);
  p_wr_tristate_r8: assert property (@(posedge clk) disable iff (!rst_n) (!wr_all_n || !wr_byte_n) |-> !dq_oe);
  // R2 precedence: a recognised processor strobe opens a read, never a write
  p_cpu_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_strobe_n && !sel1_n && !blocked) |-> (we == 2'b00));
  p_sleep_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n) blocked |-> (we == 2'b00 && !dq_oe));
  p_burst_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cont && !advance_n) |=> (idx == $past(idx) + 2'd1));
endmodule

bind burst_sram burst_sram_chk u_chk (
  .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n),
  .cpu_strobe_n(cpu_strobe_n), .sel1_n(sel1_n), .advance_n(advance_n), .dq_oe(dq_oe),
  .blocked(blocked), .active(active), .start_evt(start_evt), .desel_evt(desel_evt),
  .cont(cont), .we(we), .idx(idx)
);

// File: tb/burst_sram_bench.sv
module burst_sram_bench;
  localparam int P = 10;
  localparam logic [8:0] TBL [8] = '{
    9'b0_00011011, 9'b0_01101100, 9'b0_10110001, 9'b0_11000110,
    9'b1_00011011, 9'b1_01001110, 9'b1_10110001, 9'b1_11100100};

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] addr = '0;
  logic sel1_n, sel2, sel3_n, cpu_n, ctl_n, adv_n, wa_n, wb_n, ilv = 1'b0, slp = 1'b0, oe_n = 1'b0;
  logic [1:0] ls_n;
  logic [17:0] dq_in = '0, dq_out;
  logic dq_oe;
  int checks = 0, fails = 0;

  always #(P/2) clk = ~clk;

  burst_sram u_burst_sram (
    .clk(clk), .rst_n(rst_n), .addr(addr), .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n),
    .cpu_strobe_n(cpu_n), .ctl_strobe_n(ctl_n), .advance_n(adv_n), .wr_all_n(wa_n),
    .wr_byte_n(wb_n), .lane_sel_n(ls_n), .order_ilv(ilv), .sleep_req(slp), .oe_n(oe_n),
    .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe));

  function automatic logic [17:0] pat(input logic [7:0] a);
    return {2'b10, a, ~a};
  endfunction

  task automatic chk(input string req, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic idle();
    cpu_n = 1; ctl_n = 1; adv_n = 1; wa_n = 1; wb_n = 1; ls_n = 2'b11;
    sel1_n = 0; sel2 = 1; sel3_n = 0;
  endtask

  task automatic deselect();
    idle(); ctl_n = 0; sel2 = 0; step(); idle();
  endtask

  task automatic write_ctl(input logic [7:0] a, input logic [17:0] d, input logic w_all, input logic w_b, input logic [1:0] l);
    idle(); ctl_n = 0; addr = a; dq_in = d; wa_n = w_all; wb_n = w_b; ls_n = l;
    step(); idle();
  endtask

  task automatic read_chk(input logic [7:0] a, input logic [17:0] exp, input string req);
    deselect(); ctl_n = 0; addr = a; oe_n = 0; step(); idle(); step(); #1;
    chk(req, {17'd0, dq_oe}, 18'd1);
    chk(req, dq_out, exp);
  endtask

  initial begin
    #(P*200000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    idle();
    repeat (3) step();
    chk("R12 reset tri-state", {17'd0, dq_oe}, 18'd0);
    rst_n = 1; step();
    chk("R12 idle after reset", {17'd0, dq_oe}, 18'd0);

    for (int a = 0; a < 32; a++) write_ctl(8'(a), pat(8'(a)), 1'b0, 1'b1, 2'b11);

    // R9/R10 burst table
    for (int i = 0; i < 8; i++) begin
      deselect();
      ilv = TBL[i][8];
      cpu_n = 0; addr = {6'(i), TBL[i][7:6]}; step();
      idle(); adv_n = 0;
      for (int k = 0; k < 4; k++) begin
        if (k == 3) adv_n = 1;
        step(); #1;
        chk(ilv ? "R10 interleaved burst" : "R9 linear burst", dq_out,
            pat({6'(i), TBL[i][7-2*k -: 2]}));
      end
    end
    deselect(); ilv = 0;

    // R5 lane masks
    write_ctl(8'h40, 18'h15A5A, 0, 1, 2'b11);
    write_ctl(8'h40, 18'h00000, 1, 0, 2'b10);
    read_chk(8'h40, 18'h15A00, "R5 lane0 only");
    write_ctl(8'h40, 18'h3FFFF, 0, 1, 2'b11);
    read_chk(8'h40, 18'h3FFFF, "R5 global ignores lane selects");
    write_ctl(8'h40, 18'h00000, 1, 0, 2'b01);
    read_chk(8'h40, 18'h001FF, "R5 lane1 only");
    write_ctl(8'h40, 18'h00000, 1, 0, 2'b11);
    read_chk(8'h40, 18'h001FF, "R5 no lane selected");

    // R2 both strobes low: processor wins, write controls ignored (R3)
    write_ctl(8'h41, 18'h12345, 0, 1, 2'b11);
    deselect();
    cpu_n = 0; ctl_n = 0; addr = 8'h41; wa_n = 0; dq_in = 18'h3C3C3; step();
    idle(); step(); #1;
    chk("R2 precedence read", dq_out, 18'h12345);
    chk("R6 read latency", {17'd0, dq_oe}, 18'd1);
    read_chk(8'h41, 18'h12345, "R3 first-edge write ignored");

    // R3 processor write completes at second edge
    deselect();
    cpu_n = 0; addr = 8'h42; oe_n = 1; step();
    idle(); wa_n = 0; dq_in = 18'h2468A; step();
    idle(); oe_n = 0;
    read_chk(8'h42, 18'h2468A, "R3 two-cycle write");

    // R8 write controls force tri-state
    wb_n = 0; #1;
    chk("R8 write forces tri-state", {17'd0, dq_oe}, 18'd0);
    wb_n = 1; #1;
    chk("R8 released", {17'd0, dq_oe}, 18'd1);
    oe_n = 1; #1;
    chk("R7 oe_n high", {17'd0, dq_oe}, 18'd0);
    oe_n = 0; #1;

    // R2 processor strobe ignored with sel1_n high: burst continues
    cpu_n = 0; sel1_n = 1; step(); #1;
    chk("R2 ignored strobe keeps burst", {17'd0, dq_oe}, 18'd1);
    chk("R2 ignored strobe data", dq_out, 18'h2468A);
    idle();

    // R1 deselect via inactive chip enable
    ctl_n = 0; sel2 = 0; step(); #1;
    chk("R1 deselect tri-states", {17'd0, dq_oe}, 18'd0);
    idle();

    // R7 first-cycle mask out of deselect
    ctl_n = 0; addr = 8'h42; step(); #1;
    chk("R7 first cycle masked", {17'd0, dq_oe}, 18'd0);
    idle(); step(); #1;
    chk("R7 second cycle drives", {17'd0, dq_oe}, 18'd1);

    // R4/R9 controller write burst with wrap
    deselect();
    ctl_n = 0; addr = 8'h82; wa_n = 0; adv_n = 0; dq_in = 18'h11111; step();
    ctl_n = 1; dq_in = 18'h22222; step();
    dq_in = 18'h33333; step();
    idle();
    read_chk(8'h82, 18'h11111, "R4 advance ignored on opening write");
    read_chk(8'h83, 18'h22222, "R9 write burst step");
    read_chk(8'h80, 18'h33333, "R9 write burst wrap");

    // R11 sleep
    write_ctl(8'h90, 18'h0ABCD, 0, 1, 2'b11);
    read_chk(8'h90, 18'h0ABCD, "R11 before sleep");
    slp = 1; step(); #1;
    chk("R11 outputs off entering sleep", {17'd0, dq_oe}, 18'd0);
    ctl_n = 0; addr = 8'h90; wa_n = 0; dq_in = 18'h3FFFF;
    step(); step(); #1;
    chk("R11 outputs off asleep", {17'd0, dq_oe}, 18'd0);
    idle(); slp = 0; step();
    ctl_n = 0; addr = 8'h90; wa_n = 0; dq_in = 18'h3FFFF; step();
    idle();
    read_chk(8'h90, 18'h0ABCD, "R11 data kept, strobes ignored");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule